// File: doc/BRIEF.md
# Bus Trigger and Capture Monitor

This block watches the bus of an 8-bit microprocessor from a fast local clock and records a short burst of bus traffic after a chosen event. The operator sets a compare pattern on switch inputs: a 16-bit address plus the read, write and opcode-fetch lines. Every address bit and every control bit has its own enable, so any bit can be made don't-care. When a bus cycle matches the pattern, the block arms its capture path. It then records the data bus on each of the next five read or write cycles, into five byte slots in order, and stops.

All bus inputs pass through two-flop synchronizers. A bus cycle counts once, at the sample where its strobe goes inactive. The value stored is the data sampled while the strobe was still asserted. The cycle that fires the trigger is not recorded. A clear/re-arm pulse empties the slots and waits for a new trigger. To follow a program further, the operator steps the compare address along the execution path.

The five bytes are presented raw and as ten ASCII hex characters for a display. These outputs are plain levels with no valid/ready handshake. The bus cannot be stalled, so the block has no back-pressure path. A display reads the outputs whenever it likes, and they hold still once all slots are full.

Top module: `bus_capture_mon`

## Requirements
- R1: After reset, the state output reads armed (code 0), the fill count is 0, and all slot bytes are zero.
- R2: A bus cycle is a trigger match when two conditions hold. First, every enabled address bit equals its compare bit. Second, every enabled control bit matches its compare bit while the strobe is asserted. The control bit order is: bit 0 read, bit 1 write, bit 2 opcode-fetch. A compare value of 1 means the line is driven low. Disabled bits are don't-care. A non-matching cycle leaves the block armed.
- R3: The matching cycle moves the block from armed to capturing (code 1) and is not stored. Strobes seen while armed store nothing.
- R4: While capturing, each completed read or write cycle stores the data sampled while its strobe was asserted. Storage goes to slots 0 through 4 in order, and the fill count rises by one for each cycle. Slot k appears on `slot_data_o[8k+7:8k]`.
- R5: After the fifth store the state reads done (code 2) and the fill count reads 5.
- R6: In the done state, further strobes and trigger matches change neither the slots nor the state.
- R7: A re-arm pulse zeros all slots, sets the fill count to 0 and returns the state to armed.
- R8: A cycle in which read and write are both asserted counts as one cycle. It makes only one store.
- R9: `hex_ascii_o` carries two characters per slot. Character 2k (bits 16k+7:16k) is the high nibble of slot k, and character 2k+1 is its low nibble. Each character is an ASCII '0'-'9' or 'A'-'F'.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Monitored address bus |
| data_i | input | 8 | Monitored data bus |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| m1_n_i | input | 1 | Opcode-fetch line, active low |
| cmp_addr_i | input | 16 | Trigger compare address |
| cmp_addr_en_i | input | 16 | Per-bit address compare enable |
| cmp_ctl_i | input | 3 | Required control states (bit0 read, bit1 write, bit2 fetch; 1 = asserted) |
| cmp_ctl_en_i | input | 3 | Per-bit control compare enable |
| rearm_i | input | 1 | Synchronous clear and re-arm pulse |
| slot_data_o | output | 40 | Five captured bytes, slot k at bits 8k+7:8k |
| hex_ascii_o | output | 80 | Ten ASCII hex characters of the slots |
| state_o | output | 2 | 0 armed, 1 capturing, 2 done |
| fill_o | output | 3 | Number of slots filled |

## Verification
The bench targets the following corner cases:

- **Near-miss cycles.** A read at the trigger address without the fetch line, and a fetch one address away, must both leave the block armed. A compare that ignored control bits would trigger early.
- **Trigger cycle not stored.** After the trigger, slot 0 must hold the byte of the following cycle. A design that stored the trigger cycle would shift every slot by one.
- **Data changed at strobe release.** The data bus changes on the same sample the strobe releases, and the bench checks that the byte from inside the strobe is stored. A design that latched one sample late would store the junk value.
- **Overlapping strobes, masking and extra cycles.** A cycle with both strobes low must fill one slot, not two. An address mask must let a partial address trigger. Cycles after the fifth, including a fresh trigger match, must leave the done state and slots untouched.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_DONE    = 2'd2
  } mon_state_t;

  // Control bit positions inside the control vectors.
  localparam int CTL_RD = 0;
  localparam int CTL_WR = 1;
  localparam int CTL_M1 = 2;
  localparam int CTL_W  = 3;

  function automatic logic [7:0] nib_to_ascii(input logic [3:0] nib);
    if (nib < 4'd10) return 8'h30 + {4'h0, nib};
    else             return 8'h37 + {4'h0, nib};
  endfunction

endpackage

// File: rtl/bcm_sync.sv
module bcm_sync #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/bcm_edge.sv
// Holds the last sample of a bus cycle and flags the sample where
// its strobe releases.
module bcm_edge #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CTL_W-1:0]  ctl_act_i,
  output logic              cyc_end_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CTL_W-1:0]  ctl_act_o
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      addr_o    <= '0;
      data_o    <= '0;
      ctl_act_o <= '0;
    end else begin
      strobe_q  <= strobe_i;
      addr_o    <= addr_i;
      data_o    <= data_i;
      ctl_act_o <= ctl_act_i;
    end
  end

  assign cyc_end_o = strobe_q & ~strobe_i;

  // R8: one bus cycle, however many strobes overlap, yields one pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end_o |=> !cyc_end_o);
endmodule

// File: rtl/bcm_match.sv
module bcm_match #(
  parameter int ADDR_W = 16,
  parameter int CTL_W  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CTL_W-1:0]  ctl_act_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  input  logic [ADDR_W-1:0] cmp_addr_en_i,
  input  logic [CTL_W-1:0]  cmp_ctl_i,
  input  logic [CTL_W-1:0]  cmp_ctl_en_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] addr_ok;
  logic [CTL_W-1:0]  ctl_ok;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_abit
    assign addr_ok[i] = ~cmp_addr_en_i[i] | (addr_i[i] == cmp_addr_i[i]);
  end

  for (genvar j = 0; j < CTL_W; j++) begin : g_cbit
    assign ctl_ok[j] = ~cmp_ctl_en_i[j] | (ctl_act_i[j] == cmp_ctl_i[j]);
  end

  assign hit_o = (&addr_ok) & (&ctl_ok);
endmodule

// File: rtl/bcm_capture.sv
module bcm_capture
  import bcm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 5,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rearm_i,
  input  logic                    cyc_end_i,
  input  logic                    hit_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic [SLOTS*DATA_W-1:0] slots_o,
  output mon_state_t              state_o,
  output logic [CNT_W-1:0]        fill_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  mon_state_t       state_q;
  logic [CNT_W-1:0] fill_q;
  logic             store;

  assign store = (state_q == ST_CAPTURE) && cyc_end_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
      fill_q  <= '0;
    end else if (rearm_i) begin
      state_q <= ST_ARMED;
      fill_q  <= '0;
    end else begin
      case (state_q)
        ST_ARMED:   if (cyc_end_i && hit_i) state_q <= ST_CAPTURE;
        ST_CAPTURE: if (cyc_end_i) begin
          fill_q <= fill_q + 1'b1;
          if (fill_q == LAST) state_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slot_q <= '0;
      else if (rearm_i)                          slot_q <= '0;
      else if (store && fill_q == CNT_W'(k))     slot_q <= data_i;
    end
    assign slots_o[k*DATA_W +: DATA_W] = slot_q;
  end

  assign state_o = state_q;
  assign fill_o  = fill_q;

  // R3: nothing is stored while waiting for the trigger
  a_r3_armed_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED) |-> (fill_q == '0));
  // R4: the slot index never runs past the last slot
  a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(SLOTS));
  // R4: the fill count advances by at most one per sample
  a_r4_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
    !rearm_i |=> (fill_q == $past(fill_q) || fill_q == CNT_W'($past(fill_q) + 1'b1)));
  // R6: once done, slots and state hold until re-arm
  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && !rearm_i) |=> ($stable(slots_o) && state_q == ST_DONE));
  // R7: re-arm empties everything
  a_r7_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> (fill_q == '0 && state_q == ST_ARMED && slots_o == '0));
endmodule

// File: rtl/bus_capture_mon.sv
module bus_capture_mon
  import bcm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SLOTS  = 5,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int NIBS  = DATA_W / 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       rd_n_i,
  input  logic                       wr_n_i,
  input  logic                       m1_n_i,
  input  logic [ADDR_W-1:0]          cmp_addr_i,
  input  logic [ADDR_W-1:0]          cmp_addr_en_i,
  input  logic [CTL_W-1:0]           cmp_ctl_i,
  input  logic [CTL_W-1:0]           cmp_ctl_en_i,
  input  logic                       rearm_i,
  output logic [SLOTS*DATA_W-1:0]    slot_data_o,
  output logic [SLOTS*NIBS*8-1:0]    hex_ascii_o,
  output logic [1:0]                 state_o,
  output logic [CNT_W-1:0]           fill_o
);
  localparam int BUS_W = CTL_W + ADDR_W + DATA_W;
  localparam logic [BUS_W-1:0] BUS_RST = {{CTL_W{1'b1}}, {(ADDR_W + DATA_W){1'b0}}};

  logic [BUS_W-1:0]  bus_raw, bus_s;
  logic [CTL_W-1:0]  ctl_n_s, ctl_act_s, ctl_act_h;
  logic [ADDR_W-1:0] addr_s, addr_h;
  logic [DATA_W-1:0] data_s, data_h;
  logic              strobe_s, cyc_end, hit;
  mon_state_t        state;

  assign bus_raw = {m1_n_i, wr_n_i, rd_n_i, addr_i, data_i};

  bcm_sync #(.W(BUS_W), .RST_VAL(BUS_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(bus_raw), .q_o(bus_s));

  assign {ctl_n_s, addr_s, data_s} = bus_s;
  assign ctl_act_s = ~ctl_n_s;
  assign strobe_s  = ctl_act_s[CTL_RD] | ctl_act_s[CTL_WR];

  bcm_edge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_W(CTL_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_s),
    .addr_i(addr_s), .data_i(data_s), .ctl_act_i(ctl_act_s),
    .cyc_end_o(cyc_end), .addr_o(addr_h), .data_o(data_h), .ctl_act_o(ctl_act_h));

  bcm_match #(.ADDR_W(ADDR_W), .CTL_W(CTL_W)) u_match (
    .addr_i(addr_h), .ctl_act_i(ctl_act_h),
    .cmp_addr_i(cmp_addr_i), .cmp_addr_en_i(cmp_addr_en_i),
    .cmp_ctl_i(cmp_ctl_i), .cmp_ctl_en_i(cmp_ctl_en_i),
    .hit_o(hit));

  bcm_capture #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_cap (
    .clk(clk), .rst_n(rst_n), .rearm_i(rearm_i),
    .cyc_end_i(cyc_end), .hit_i(hit), .data_i(data_h),
    .slots_o(slot_data_o), .state_o(state), .fill_o(fill_o));

  assign state_o = state;

  // Character order per slot: most significant nibble first.
  for (genvar k = 0; k < SLOTS; k++) begin : g_hex
    for (genvar n = 0; n < NIBS; n++) begin : g_nib
      assign hex_ascii_o[(k*NIBS + n)*8 +: 8] =
        nib_to_ascii(slot_data_o[k*DATA_W + (NIBS-1-n)*4 +: 4]);
    end
  end

  // R2: a disabled compare never lets the block leave armed without a cycle end
  a_r2_trigger_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !rearm_i && !cyc_end) |=> (state == ST_ARMED));
endmodule

// File: tb/bus_capture_mon_bench.sv
module bus_capture_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic [15:0] cmp_addr = '0, cmp_addr_en = '0;
  logic [2:0]  cmp_ctl = '0, cmp_ctl_en = '0;
  logic        rearm = 1'b0;
  logic [39:0] slots;
  logic [79:0] hexs;
  logic [1:0]  state;
  logic [2:0]  fill;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  bus_capture_mon u_bus_capture_mon (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .data_i(data),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .m1_n_i(m1_n),
    .cmp_addr_i(cmp_addr), .cmp_addr_en_i(cmp_addr_en),
    .cmp_ctl_i(cmp_ctl), .cmp_ctl_en_i(cmp_ctl_en), .rearm_i(rearm),
    .slot_data_o(slots), .hex_ascii_o(hexs), .state_o(state), .fill_o(fill));

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One bus cycle. Data turns to junk on the same edge the strobes release.
  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d,
                           input logic rd, input logic wr, input logic m1);
    @(negedge clk);
    addr = a; data = d; rd_n = ~rd; wr_n = ~wr; m1_n = ~m1;
    repeat (4) @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1; data = 8'hEE;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_rearm;
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
  endtask

  function automatic logic [7:0] asc(input logic [3:0] n);
    return (n < 10) ? 8'h30 + 8'(n) : 8'h41 + 8'(n - 10);
  endfunction

  task automatic t_reset;
    check("R1 state", 80'(state), 80'd0);
    check("R1 fill", 80'(fill), 80'd0);
    check("R1 slots", 80'(slots), 80'd0);
    check("R9 reset chars", hexs, {10{8'h30}});
  endtask

  task automatic t_fetch_trace;
    cmp_addr = 16'h0000; cmp_addr_en = 16'hFFFF;
    cmp_ctl = 3'b101; cmp_ctl_en = 3'b111;    // fetch + read, no write
    bus_cycle(16'h0000, 8'h11, 1, 0, 0);       // read without fetch
    check("R2 no-fetch miss", 80'(state), 80'd0);
    bus_cycle(16'h0001, 8'h22, 1, 0, 1);       // fetch at wrong address
    check("R2 addr miss", 80'(state), 80'd0);
    check("R3 armed stores nothing", 80'(fill), 80'd0);
    bus_cycle(16'h0000, 8'h3E, 1, 0, 1);       // the trigger
    check("R3 capturing", 80'(state), 80'd1);
    check("R3 trigger not stored", 80'(fill), 80'd0);
    bus_cycle(16'h0001, 8'h42, 1, 0, 0);
    bus_cycle(16'hFFFE, 8'h12, 0, 1, 0);
    check("R4 fill after two", 80'(fill), 80'd2);
    bus_cycle(16'hFFFD, 8'h34, 0, 1, 0);
    bus_cycle(16'h0002, 8'h56, 1, 0, 0);
    check("R4 still capturing", 80'(state), 80'd1);
    bus_cycle(16'h0003, 8'hB8, 1, 0, 1);
    check("R4 slot order", 80'(slots), 80'({8'hB8, 8'h56, 8'h34, 8'h12, 8'h42}));
    check("R5 done", 80'(state), 80'd2);
    check("R5 fill five", 80'(fill), 80'd5);
    check("R9 slot0 chars", 80'(hexs[15:0]), 80'({asc(4'h2), asc(4'h4)}));
    check("R9 slot4 chars", 80'(hexs[79:64]), 80'({asc(4'h8), asc(4'hB)}));
    bus_cycle(16'h0000, 8'h99, 1, 0, 1);       // matching again, and a write
    bus_cycle(16'h0010, 8'h77, 0, 1, 0);
    check("R6 slots frozen", 80'(slots), 80'({8'hB8, 8'h56, 8'h34, 8'h12, 8'h42}));
    check("R6 still done", 80'(state), 80'd2);
  endtask

  task automatic t_rearm;
    pulse_rearm();
    check("R7 state", 80'(state), 80'd0);
    check("R7 fill", 80'(fill), 80'd0);
    check("R7 slots", 80'(slots), 80'd0);
  endtask

  task automatic t_mask_overlap;
    cmp_addr = 16'h1234; cmp_addr_en = 16'hFF00;
    cmp_ctl = 3'b010; cmp_ctl_en = 3'b010;     // only: write asserted
    bus_cycle(16'h12AB, 8'h01, 1, 0, 0);       // read, should miss
    check("R2 ctl miss", 80'(state), 80'd0);
    bus_cycle(16'h12AB, 8'h02, 0, 1, 0);       // masked low byte
    check("R2 masked hit", 80'(state), 80'd1);
    bus_cycle(16'h5555, 8'hA5, 1, 1, 0);       // both strobes
    check("R8 one store", 80'(fill), 80'd1);
    check("R8 slot0", 80'(slots[7:0]), 80'hA5);
    check("R8 slot1 empty", 80'(slots[15:8]), 80'h00);
    pulse_rearm();
    check("R7 rearm mid-capture", 80'(state), 80'd0);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_fetch_trace();
    t_rearm();
    t_mask_overlap();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule